// File: doc/BRIEF.md
# Span Z and Colour Interpolator

The block walks one horizontal run of pixels for a raster graphics engine. Software first writes a small set of configuration words through an indexed load port: a control word, a signed pixel count, a start address, start values for depth and three colour channels, and a per-pixel slope for each of them. A start strobe then launches the walk. On every following cycle the block presents one pixel: its frame-buffer address, the clamped integer colour, the integer depth, and a write enable. The run ends with a one-cycle completion pulse.

The write enable combines two filters. A depth test compares the pixel's new depth with the stored depth that the memory side returns on `old_z` in the same cycle. A 16-bit screen-door pattern, indexed by the low address bits, can also drop individual pixels. Depth arithmetic runs in either a narrow 16.12 or a wide 24.12 fixed-point format. Control bits can freeze depth, colour or address at their start values, and a single-channel mode leaves only the blue channel live.

The controller has three named states. `ST_IDLE` waits for the strobe and moves to `ST_RUN` when the count is non-zero, or to `ST_DONE` when it is zero. `ST_RUN` emits one pixel per cycle and moves to `ST_DONE` after the last one. `ST_DONE` raises the completion pulse for one cycle and always returns to `ST_IDLE`.

Top module: `span_interp`

## Requirements
- R1: After reset, `pix_valid`, `pix_we` and `done` are 0.
- R2: A start strobe in idle with count N yields exactly |N| consecutive cycles of `pix_valid`, starting the cycle after the strobe. `done` is high for the single cycle after the last pixel. With N = 0, `done` is high in the cycle after the strobe and no pixel is emitted.
- R3: The first pixel address is the loaded start address. Each later pixel address is the previous one plus 1 if N > 0, or minus 1 if N < 0, modulo 2^24.
- R4: Colour start values are unsigned 8.12 and slopes are two's complement 8.12. Pixel i shows the integer part of start + i*slope, clamped to 0..255.
- R5: Control bit 20 selects depth precision: 1 for 24.12 (36-bit, wraps modulo 2^36), 0 for 16.12 (uses the low 28 bits of the start and slope, wraps modulo 2^28). `pix_z` is the integer part of the depth accumulator.
- R6: Control bits 21, 22 and 23 enable the write when the new depth integer is less than, greater than or equal to the old depth, respectively. The enabled outcomes are ORed. In 16.12 mode only `old_z[15:0]` is compared.
- R7: Control bits 15:0 form a screen-door mask. Bit k belongs to pixels whose address has low nibble k, and a 0 forces `pix_we` low. `pix_we` is never high without `pix_valid`.
- R8: Control bit 16 freezes depth, bit 17 freezes all colour channels, and bit 18 freezes the address, each at its start value for the whole run.
- R9: Control bit 19 selects single-channel mode: `pix_r` and `pix_g` read 0 and `pix_b` is interpolated normally.
- R10: A start strobe while a run or its completion cycle is in progress is ignored, and the run length is unchanged.
- R11: The load port writes `ld_data` to register `ld_idx` when `ld_en` is high. The registers are: 0 control, 1 count (13-bit two's complement), 2 address, 3 depth start, 4 depth slope, 5/6 blue start/slope, 7/8 red start/slope, 9/10 green start/slope. Values are taken from these registers at the start strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Configuration write strobe |
| ld_idx | input | 4 | Configuration register index |
| ld_data | input | 36 | Configuration write data |
| start | input | 1 | Launches a run when idle |
| old_z | input | 24 | Stored depth for the current pixel address |
| pix_valid | output | 1 | A pixel is presented this cycle |
| pix_addr | output | 24 | Pixel address |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |
| pix_z | output | 24 | New depth integer |
| pix_we | output | 1 | Pixel write enable |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Random runs mix both count signs, both depth precisions, every compare code, random masks, random freeze bits and both colour modes. The stored-depth input is scrambled from the address, so each compare direction and each mask bit is exercised. Directed runs cover a zero count, a downward run that crosses address zero, clamping at both ends of the colour range, and an exact depth match. An exact match separates the equal bit from the less-than and greater-than bits. A strobe issued mid-run shows that a second run cannot be started on top of the first.

// File: rtl/span_pkg.sv
package span_pkg;
    parameter int CNT_W    = 13;
    parameter int ADDR_W   = 24;
    parameter int COL_I    = 8;
    parameter int COL_F    = 12;
    parameter int ZI_NAR   = 16;
    parameter int ZI_WIDE  = 24;
    parameter int Z_F      = 12;
    parameter int MASK_W   = 16;
    parameter int CMP_W    = 3;
    parameter int NCH      = 3;
    parameter int IDX_W    = 4;

    localparam int COL_W   = COL_I + COL_F;
    localparam int Z_W     = ZI_WIDE + Z_F;
    localparam int ZN_W    = ZI_NAR + Z_F;
    localparam int LD_W    = Z_W;
    localparam int MIDX_W  = $clog2(MASK_W);

    // control word bit positions
    localparam int B_ZHOLD  = MASK_W;
    localparam int B_CHOLD  = MASK_W + 1;
    localparam int B_AHOLD  = MASK_W + 2;
    localparam int B_MONO   = MASK_W + 3;
    localparam int B_WIDEZ  = MASK_W + 4;
    localparam int B_CMP    = MASK_W + 5;

    // channel order: 0 blue, 1 red, 2 green
    typedef struct packed {
        logic [MASK_W-1:0]          mask;
        logic                       zhold;
        logic                       chold;
        logic                       ahold;
        logic                       mono;
        logic                       widez;
        logic [CMP_W-1:0]           cmp;
        logic [CNT_W-1:0]           count;
        logic [ADDR_W-1:0]          addr;
        logic [Z_W-1:0]             z0;
        logic [Z_W-1:0]             zs;
        logic [NCH-1:0][COL_W-1:0]  c0;
        logic [NCH-1:0][COL_W-1:0]  cs;
    } span_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } span_state_t;
endpackage

// File: rtl/span_regs.sv
module span_regs
    import span_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [LD_W-1:0]  ld_data,
    output span_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            cfg.mask <= '1;
        end else if (ld_en) begin
            unique case (ld_idx)
                4'd0: begin
                    cfg.mask  <= ld_data[MASK_W-1:0];
                    cfg.zhold <= ld_data[B_ZHOLD];
                    cfg.chold <= ld_data[B_CHOLD];
                    cfg.ahold <= ld_data[B_AHOLD];
                    cfg.mono  <= ld_data[B_MONO];
                    cfg.widez <= ld_data[B_WIDEZ];
                    cfg.cmp   <= ld_data[B_CMP +: CMP_W];
                end
                4'd1:  cfg.count <= ld_data[CNT_W-1:0];
                4'd2:  cfg.addr  <= ld_data[ADDR_W-1:0];
                4'd3:  cfg.z0    <= ld_data[Z_W-1:0];
                4'd4:  cfg.zs    <= ld_data[Z_W-1:0];
                4'd5:  cfg.c0[0] <= ld_data[COL_W-1:0];
                4'd6:  cfg.cs[0] <= ld_data[COL_W-1:0];
                4'd7:  cfg.c0[1] <= ld_data[COL_W-1:0];
                4'd8:  cfg.cs[1] <= ld_data[COL_W-1:0];
                4'd9:  cfg.c0[2] <= ld_data[COL_W-1:0];
                4'd10: cfg.cs[2] <= ld_data[COL_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/span_chan.sv
module span_chan #(
    parameter int IW   = 8,
    parameter int FW   = 12,
    parameter int CNTW = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            hold,
    input  logic [IW+FW-1:0] init,
    input  logic [IW+FW-1:0] slope,
    output logic [IW-1:0]    level
);
    localparam int CW = IW + FW;
    localparam int AW = CW + CNTW + 1;

    logic [AW-1:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (load)
            acc <= {{(AW-CW){1'b0}}, init};
        else if (step && !hold)
            acc <= acc + {{(AW-CW){slope[CW-1]}}, slope};
    end

    always_comb begin
        if (acc[AW-1])
            level = '0;
        else if (|acc[AW-2:FW+IW])
            level = '1;
        else
            level = acc[FW+IW-1:FW];
    end

    // R8: a frozen channel keeps its accumulator
    p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hold && !load) |=> $stable(acc));
endmodule

// File: rtl/span_zunit.sv
module span_zunit
    import span_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               hold,
    input  logic               wide_in,
    input  logic [Z_W-1:0]     init,
    input  logic [Z_W-1:0]     slope,
    input  logic [ZI_WIDE-1:0] old_z,
    input  logic [CMP_W-1:0]   cmp,
    output logic [ZI_WIDE-1:0] z_int,
    output logic               z_pass
);
    logic [Z_W-1:0]     acc;
    logic [Z_W-1:0]     sum;
    logic [Z_W-1:0]     slope_eff;
    logic [ZI_WIDE-1:0] old_eff;
    logic               wide;

    always_comb begin
        slope_eff = wide ? slope : {{(Z_W-ZN_W){slope[ZN_W-1]}}, slope[ZN_W-1:0]};
        sum       = acc + slope_eff;
        old_eff   = wide ? old_z : {{(ZI_WIDE-ZI_NAR){1'b0}}, old_z[ZI_NAR-1:0]};
        z_int     = acc[Z_W-1:Z_F];
        z_pass    = (cmp[0] && (z_int <  old_eff)) ||
                    (cmp[1] && (z_int >  old_eff)) ||
                    (cmp[2] && (z_int == old_eff));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            wide <= 1'b0;
        end else if (load) begin
            wide <= wide_in;
            acc  <= wide_in ? init : {{(Z_W-ZN_W){1'b0}}, init[ZN_W-1:0]};
        end else if (step && !hold) begin
            acc  <= wide ? sum : {{(Z_W-ZN_W){1'b0}}, sum[ZN_W-1:0]};
        end
    end

    // R8: frozen depth stays put
    p_z_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hold && !load) |=> $stable(z_int));
    // R5: narrow mode never shows integer bits above 16
    p_z_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (z_int[ZI_WIDE-1:ZI_NAR] == '0));
endmodule

// File: rtl/span_interp.sv
module span_interp
    import span_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [3:0]         ld_idx,
    input  logic [35:0]        ld_data,
    input  logic               start,
    input  logic [23:0]        old_z,
    output logic               pix_valid,
    output logic [23:0]        pix_addr,
    output logic [7:0]         pix_r,
    output logic [7:0]         pix_g,
    output logic [7:0]         pix_b,
    output logic [23:0]        pix_z,
    output logic               pix_we,
    output logic               done
);
    span_cfg_t          cfg;
    span_state_t        state, state_nx;
    logic [CNT_W-1:0]   remain;
    logic [CNT_W-1:0]   mag;
    logic [ADDR_W-1:0]  addr;
    logic               go, step;
    logic               down, ahold, chold, zhold, mono;
    logic [MASK_W-1:0]  mask;
    logic [CMP_W-1:0]   cmp;
    logic [NCH-1:0][COL_I-1:0] lvl;
    logic               z_pass;

    span_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .cfg(cfg)
    );

    assign mag  = cfg.count[CNT_W-1] ? (~cfg.count + 1'b1) : cfg.count;
    assign go   = (state == ST_IDLE) && start;
    assign step = (state == ST_RUN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (mag == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (remain == 1) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // run datapath: counter, address, latched controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            addr   <= '0;
            down   <= 1'b0;
            ahold  <= 1'b0;
            chold  <= 1'b0;
            zhold  <= 1'b0;
            mono   <= 1'b0;
            mask   <= '1;
            cmp    <= '0;
        end else if (go) begin
            remain <= mag;
            addr   <= cfg.addr;
            down   <= cfg.count[CNT_W-1];
            ahold  <= cfg.ahold;
            chold  <= cfg.chold;
            zhold  <= cfg.zhold;
            mono   <= cfg.mono;
            mask   <= cfg.mask;
            cmp    <= cfg.cmp;
        end else if (step) begin
            remain <= remain - 1'b1;
            if (!ahold)
                addr <= down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        span_chan #(.IW(COL_I), .FW(COL_F), .CNTW(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(go), .step(step), .hold(chold),
            .init(cfg.c0[c]), .slope(cfg.cs[c]), .level(lvl[c])
        );
    end

    span_zunit u_z (
        .clk(clk), .rst_n(rst_n), .load(go), .step(step), .hold(zhold),
        .wide_in(cfg.widez), .init(cfg.z0), .slope(cfg.zs),
        .old_z(old_z), .cmp(cmp), .z_int(pix_z), .z_pass(z_pass)
    );

    // outputs
    always_comb begin
        pix_valid = (state == ST_RUN);
        done      = (state == ST_DONE);
        pix_addr  = addr;
        pix_b     = lvl[0];
        pix_r     = mono ? '0 : lvl[1];
        pix_g     = mono ? '0 : lvl[2];
        pix_we    = pix_valid && mask[addr[MIDX_W-1:0]] && z_pass;
    end

    p_we_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> pix_valid);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !pix_valid);
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && !ahold) |->
            (pix_addr == (down ? $past(pix_addr) - 1'b1 : $past(pix_addr) + 1'b1)));
    p_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && mono) |-> (pix_r == '0 && pix_g == '0));
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid)) |-> (remain == $past(remain) - 1'b1));
endmodule

// File: tb/test_span_interp.sv
module test_span_interp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [35:0] ld_data = '0;
    logic        start = 1'b0;
    logic [23:0] old_z;
    logic        pix_valid, pix_we, done;
    logic [23:0] pix_addr, pix_z;
    logic [7:0]  pix_r, pix_g, pix_b;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    // old-depth source
    logic        oz_fix = 1'b0;
    logic [23:0] oz_val = '0;
    logic [23:0] oz_salt = '0;

    function automatic logic [23:0] oz_of(logic [23:0] a);
        return oz_fix ? oz_val : ({a[11:0], a[23:12]} ^ oz_salt);
    endfunction

    assign old_z = oz_of(pix_addr);

    span_interp i_span_interp (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .start(start), .old_z(old_z),
        .pix_valid(pix_valid), .pix_addr(pix_addr), .pix_r(pix_r),
        .pix_g(pix_g), .pix_b(pix_b), .pix_z(pix_z), .pix_we(pix_we),
        .done(done)
    );

    always #2 clk = ~clk;

    // test configuration
    logic [15:0] t_mask;
    logic        t_zh, t_ch, t_ah, t_mono, t_wide;
    logic [2:0]  t_cmp;
    int          t_cnt;
    logic [23:0] t_addr;
    logic [35:0] t_z0, t_zs;
    logic [19:0] t_c0 [3];
    logic [19:0] t_cs [3];

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [35:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 4'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic int col_exp(logic [19:0] st, logic [19:0] sl, int i);
        longint s = longint'($signed(sl));
        longint v = longint'(st) + longint'(i) * s;
        longint ip = v >>> 12;
        if (ip < 0) return 0;
        if (ip > 255) return 255;
        return int'(ip);
    endfunction

    function automatic longint z_exp(int i);
        longint v, s;
        if (t_wide) begin
            s = longint'($signed(t_zs));
            v = (longint'(t_z0) + longint'(i) * s) & 64'hF_FFFF_FFFF;
        end else begin
            s = longint'($signed(t_zs[27:0]));
            v = (longint'(t_z0[27:0]) + longint'(i) * s) & 64'hFFF_FFFF;
        end
        return v >>> 12;
    endfunction

    task automatic run_span(bit poke);
        int n;
        int k;
        logic [23:0] a;
        longint ze, oe;
        bit we;
        wr(0, {12'd0, t_cmp, t_wide, t_mono, t_ah, t_ch, t_zh, t_mask});
        wr(1, 36'(t_cnt & 32'h1FFF));
        wr(2, {12'd0, t_addr});
        wr(3, t_z0);
        wr(4, t_zs);
        for (int c = 0; c < 3; c++) begin
            wr(5 + 2 * c, {16'd0, t_c0[c]});
            wr(6 + 2 * c, {16'd0, t_cs[c]});
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = (t_cnt < 0) ? -t_cnt : t_cnt;
        for (int i = 0; i < n; i++) begin
            k = (t_ch) ? 0 : i;
            a = t_ah ? t_addr : ((t_cnt < 0) ? t_addr - 24'(i) : t_addr + 24'(i));
            ze = z_exp(t_zh ? 0 : i);
            oe = t_wide ? longint'(oz_of(a)) : longint'(oz_of(a) & 24'hFFFF);
            we = t_mask[a[3:0]] && ((t_cmp[0] && ze < oe) ||
                 (t_cmp[1] && ze > oe) || (t_cmp[2] && ze == oe));
            check(poke ? "R10 valid during busy strobe" : "R2 pixel valid", pix_valid, 1);
            check(t_ah ? "R8 address frozen" : "R3 address", pix_addr, a);
            check(t_ch ? "R8 blue frozen" : "R4 blue level", pix_b, col_exp(t_c0[0], t_cs[0], k));
            check(t_mono ? "R9 red zero" : "R4 red level", pix_r,
                  t_mono ? 0 : col_exp(t_c0[1], t_cs[1], k));
            check(t_mono ? "R9 green zero" : "R4 green level", pix_g,
                  t_mono ? 0 : col_exp(t_c0[2], t_cs[2], k));
            check(t_zh ? "R8 depth frozen" : "R5 depth", pix_z, ze);
            check("R6 R7 write enable", pix_we, we);
            start = (poke && i == 1) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check("R2 done after last pixel", done, 1);
        check("R2 no pixel at done", pix_valid, 0);
        @(negedge clk);
        check(poke ? "R10 no second run" : "R2 done is one cycle", done, 0);
        check(poke ? "R10 idle after run" : "R2 idle after run", pix_valid, 0);
    endtask

    task automatic defaults();
        t_mask = 16'hFFFF; t_zh = 0; t_ch = 0; t_ah = 0; t_mono = 0; t_wide = 0;
        t_cmp = 3'b111; t_cnt = 4; t_addr = 24'h100; t_z0 = 36'h0_0010_0000;
        t_zs = 36'h0_0000_1000;
        for (int c = 0; c < 3; c++) begin
            t_c0[c] = 20'h10000; t_cs[c] = 20'h00800;
        end
        oz_fix = 0; oz_salt = 24'h5A5A5A;
    endtask

    initial begin
        void'($urandom(32'd1234));
        defaults();
        repeat (3) @(negedge clk);
        check("R1 valid at reset", pix_valid, 0);
        check("R1 done at reset", done, 0);
        check("R1 we at reset", pix_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", pix_valid, 0);

        // R2 zero-length run
        defaults(); t_cnt = 0; run_span(0);
        // R3 R11 downward run across zero
        defaults(); t_cnt = -6; t_addr = 24'h000002; run_span(0);
        // R4 clamping at both ends
        defaults(); t_cnt = 12;
        t_c0[0] = 20'hFA000; t_cs[0] = 20'h03000;
        t_c0[1] = 20'h05000; t_cs[1] = 20'hFE000;
        t_c0[2] = 20'h80000; t_cs[2] = 20'h00123;
        run_span(0);
        // R6 exact match: equal only, then less-than only
        defaults(); t_zh = 1; t_z0 = 36'h0_0123_4000; oz_fix = 1; oz_val = 24'h001234;
        t_cmp = 3'b100; run_span(0);
        t_cmp = 3'b001; run_span(0);
        t_cmp = 3'b010; oz_val = 24'h001233; run_span(0);
        // R5 wide precision with negative slope
        defaults(); t_wide = 1; t_z0 = 36'h8_0000_0800; t_zs = 36'hF_FFFF_E800; t_cnt = 9;
        run_span(0);
        // R7 R9 sparse mask and single channel
        defaults(); t_mask = 16'h8421; t_mono = 1; t_cnt = 20; run_span(0);
        // R10 strobe during a run
        defaults(); t_cnt = 7; run_span(1);

        // random runs
        for (int r = 0; r < 30; r++) begin
            t_mask = 16'($urandom);
            t_zh = 1'($urandom % 5 == 0);
            t_ch = 1'($urandom % 5 == 0);
            t_ah = 1'($urandom % 6 == 0);
            t_mono = 1'($urandom % 4 == 0);
            t_wide = 1'($urandom);
            t_cmp = 3'($urandom);
            t_cnt = int'($urandom % 81) - 40;
            t_addr = 24'($urandom);
            t_z0 = {4'($urandom), 32'($urandom)};
            t_zs = ($urandom % 2) ? {36{1'b1}} - 36'($urandom % 32'h40000)
                                  : 36'($urandom % 32'h40000);
            for (int c = 0; c < 3; c++) begin
                t_c0[c] = 20'($urandom);
                t_cs[c] = 20'($signed(20'($urandom % 32'h8000)) - 20'sh4000);
            end
            oz_fix = 0; oz_salt = 24'($urandom);
            run_span(($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule